// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Software Refill

This block is a small, fully associative translation cache for a 16-bit virtual address space divided into 256-byte pages. Each lookup presents an address-space tag and a virtual address. The upper byte of the address is the virtual page number and the lower byte is the page offset. The block answers one cycle later. A hit returns a physical address built from the stored frame number and the unchanged offset. A miss raises a flag, and the buffer takes no further action on it.

Misses are resolved outside the block. A handler reads its own mapping structures and writes the translation back through the fill port. An entry is selected only when its address-space tag and its page number both agree with the lookup. Mappings from several processes can therefore sit side by side in the buffer. A fill whose tag is already present updates that entry in place. A new tag goes into the slot named by a round-robin pointer. A flush input invalidates the whole buffer in one cycle.

The lookup sequencer has two states. `LK_IDLE` means no response is pending. `LK_RESP` means a registered answer is on the outputs. The transition `T_ACCEPT` (IDLE to RESP) is taken when the request strobe is high. The transition `T_CHAIN` (RESP to RESP) is taken for back-to-back requests. The transition `T_DRAIN` (RESP to IDLE) is taken when no request follows.

Top module: `asid_tlb`

## Requirements
- R1: The virtual address is split into page number `lk_va[15:8]` and offset `lk_va[7:0]`. On a hit, `rsp_pa` equals `{PFN, offset}`; for example, page 0xBB mapped to frame 0x91 turns 0xBB13 into 0x9113. On a miss, `rsp_pa` is 0.
- R2: A hit requires a valid entry whose address-space tag and page number both equal the lookup values. An entry with the same page number but another tag does not hit, so mappings of different tags for one page coexist.
- R3: An entry written with `wr_valid`=0 never hits, even when its tag and page number match.
- R4: `rsp_valid`, together with exactly one of `rsp_hit` and `rsp_miss`, is high in the cycle after `lk_req` and low otherwise. The answer reflects the buffer contents before any fill or flush that is accepted on the same edge.
- R5: A lookup whose translation is absent reports a miss. After the handler fills that translation, the same lookup hits.
- R6: A fill whose tag and page number match a valid entry overwrites that entry's frame number and valid bit in place. No other entry changes, and the round-robin pointer does not move.
- R7: A fill with `wr_valid`=1 whose tag and page number match no valid entry goes into the slot at the round-robin pointer. The pointer starts at 0 after reset and then advances by one, wrapping from ENTRIES-1 to 0. It does not skip slots that are already invalid.
- R8: `flush` clears every valid bit at one edge. A fill in the same cycle is discarded and leaves the pointer unchanged.
- R9: A fill with `wr_valid`=0 that matches no valid entry is dropped. It evicts nothing and leaves the pointer unchanged.
- R10: While `rst_n` is low, all entries are invalid, the pointer is 0 and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup strobe |
| lk_asid | input | 8 | Address-space tag of the lookup |
| lk_va | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Registered answer present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; refill needed |
| rsp_pa | output | 16 | Physical address on a hit, else 0 |
| wr_en | input | 1 | Fill strobe from the miss handler |
| wr_asid | input | 8 | Address-space tag of the fill |
| wr_vpn | input | 8 | Page number of the fill |
| wr_pfn | input | 8 | Frame number of the fill |
| wr_valid | input | 1 | Valid bit to store |

## Verification
Every page number is swept under two address-space tags against a loaded buffer, with the offset varied. A design that compares only page numbers would return one process's frame to another, and a design that alters the offset would give wrong addresses. The bench then rewrites and invalidates an existing tag and checks that no second copy appears and that the victim pointer does not move; a design that always fills at the pointer would evict a live neighbour. It also drives a dropped invalid fill, a flush that coincides with a fill, and a lookup that coincides with a fill. A design that answers from post-write contents, or lets the write beat the flush, would report hits where misses are due.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [0:0] {
        LK_IDLE = 1'b0,
        LK_RESP = 1'b1
    } lk_state_t;
endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              wr_commit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_valid,
    output logic              wr_match,
    output logic [IDX_W-1:0]  wr_match_idx
);
    logic [ASID_W-1:0] asid_q [ENTRIES];
    logic [VPN_W-1:0]  vpn_q  [ENTRIES];
    logic [PFN_W-1:0]  pfn_q  [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] wr_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_vec[g] = valid_q[g] && (asid_q[g] == lk_asid) && (vpn_q[g] == lk_vpn);
        assign wr_vec[g] = valid_q[g] && (asid_q[g] == wr_asid) && (vpn_q[g] == wr_vpn);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                asid_q[i] <= '0;
                vpn_q[i]  <= '0;
                pfn_q[i]  <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_commit) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    asid_q[i]  <= wr_asid;
                    vpn_q[i]   <= wr_vpn;
                    pfn_q[i]   <= wr_pfn;
                    valid_q[i] <= wr_valid;
                end
            end
        end
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
    end

    always_comb begin
        wr_match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_vec[i]) wr_match_idx = wr_match_idx | IDX_W'(i);
        end
    end

    assign lk_hit   = |lk_vec;
    assign wr_match = |wr_vec;

    // R6
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R3
    invalid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !flush && !wr_valid) |=> !valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_lookup_fsm.sv
module tlb_lookup_fsm
    import tlb_pkg::*;
#(
    parameter int PFN_W = 8,
    parameter int OFF_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_req,
    input  logic [OFF_W-1:0]       lk_off,
    input  logic                   arr_hit,
    input  logic [PFN_W-1:0]       arr_pfn,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic [PFN_W+OFF_W-1:0] rsp_pa
);
    lk_state_t        state_q, state_d;
    logic             hit_q;
    logic [PFN_W-1:0] pfn_q;
    logic [OFF_W-1:0] off_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (lk_req) state_d = LK_RESP;   // T_ACCEPT
            LK_RESP: state_d = lk_req ? LK_RESP        // T_CHAIN
                                      : LK_IDLE;       // T_DRAIN
            default: state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            hit_q   <= 1'b0;
            pfn_q   <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            if (lk_req) begin
                hit_q <= arr_hit;
                pfn_q <= arr_pfn;
                off_q <= lk_off;
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q == LK_RESP);
        rsp_hit   = rsp_valid && hit_q;
        rsp_miss  = rsp_valid && !hit_q;
        rsp_pa    = rsp_hit ? {pfn_q, off_q} : '0;
    end

    // R4
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R4
    no_idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[OFF_W-1:0] == $past(lk_off)));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int VA_W    = 16,
    parameter int OFF_W   = 8,
    parameter int PFN_W   = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   lk_req,
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic [VA_W-1:0]        lk_va,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic [PFN_W+OFF_W-1:0] rsp_pa,
    input  logic                   wr_en,
    input  logic [ASID_W-1:0]      wr_asid,
    input  logic [VPN_W-1:0]       wr_vpn,
    input  logic [PFN_W-1:0]       wr_pfn,
    input  logic                   wr_valid
);
    logic             arr_hit;
    logic [PFN_W-1:0] arr_pfn;
    logic             wr_match;
    logic [IDX_W-1:0] wr_match_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_commit;
    logic             new_fill;

    assign new_fill  = wr_en && !flush && !wr_match && wr_valid;
    assign wr_commit = wr_en && !flush && (wr_match || wr_valid);
    assign wr_idx    = wr_match ? wr_match_idx : victim;

    tlb_entry_array #(
        .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .lk_asid     (lk_asid),
        .lk_vpn      (lk_va[VA_W-1:OFF_W]),
        .lk_hit      (arr_hit),
        .lk_pfn      (arr_pfn),
        .wr_commit   (wr_commit),
        .wr_idx      (wr_idx),
        .wr_asid     (wr_asid),
        .wr_vpn      (wr_vpn),
        .wr_pfn      (wr_pfn),
        .wr_valid    (wr_valid),
        .wr_match    (wr_match),
        .wr_match_idx(wr_match_idx)
    );

    tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (new_fill),
        .ptr  (victim)
    );

    tlb_lookup_fsm #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_off   (lk_va[OFF_W-1:0]),
        .arr_hit  (arr_hit),
        .arr_pfn  (arr_pfn),
        .rsp_valid(rsp_valid),
        .rsp_hit  (rsp_hit),
        .rsp_miss (rsp_miss),
        .rsp_pa   (rsp_pa)
    );

    // R6
    inplace_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_match) |=> $stable(victim));

    // R8
    flush_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(victim));

    // R9
    drop_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> $stable(victim));
endmodule

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic [15:0] lk_va = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_asid = '0, wr_vpn = '0, wr_pfn = '0;
    logic        wr_valid = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [15:0] rsp_pa;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_asid [N];
    logic [7:0] m_vpn  [N];
    logic [7:0] m_pfn  [N];
    bit         m_v    [N];
    int         m_ptr = 0;

    always #2.5 clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_req(lk_req), .lk_asid(lk_asid), .lk_va(lk_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
        .wr_en(wr_en), .wr_asid(wr_asid), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_valid(wr_valid)
    );

    task automatic step(input bit lk, input logic [7:0] la, input logic [15:0] va,
                        input bit wr, input logic [7:0] wa, input logic [7:0] wv,
                        input logic [7:0] wp, input bit wval, input bit fl,
                        input string req);
        bit eh;
        logic [15:0] epa;
        int m;
        @(negedge clk);
        eh = 0; epa = '0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_asid[i] == la && m_vpn[i] == va[15:8]) begin
                eh = 1; epa = {m_pfn[i], va[7:0]};
            end
        lk_req = lk; lk_asid = la; lk_va = va;
        wr_en = wr; wr_asid = wa; wr_vpn = wv; wr_pfn = wp; wr_valid = wval;
        flush = fl;
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (wr) begin
            m = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_asid[i] == wa && m_vpn[i] == wv) m = i;
            if (m >= 0) begin
                m_pfn[m] = wp; m_v[m] = wval;
            end else if (wval) begin
                m_asid[m_ptr] = wa; m_vpn[m_ptr] = wv; m_pfn[m_ptr] = wp; m_v[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        @(negedge clk);
        lk_req = 0; wr_en = 0; flush = 0;
        applied++;
        if (lk) begin
            if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh ||
                rsp_pa !== epa) begin
                bad++;
                $display("FAIL %s: asid=%h va=%h got v=%b h=%b m=%b pa=%h, expected v=1 h=%b m=%b pa=%h",
                         req, la, va, rsp_valid, rsp_hit, rsp_miss, rsp_pa, eh, !eh, epa);
            end
        end else if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            bad++;
            $display("FAIL %s: idle cycle got v=%b h=%b m=%b, expected all 0",
                     req, rsp_valid, rsp_hit, rsp_miss);
        end
    endtask

    task automatic lookup(input logic [7:0] la, input logic [15:0] va, input string req);
        step(1, la, va, 0, 8'h0, 8'h0, 8'h0, 0, 0, req);
    endtask

    task automatic fill(input logic [7:0] wa, input logic [7:0] wv, input logic [7:0] wp,
                        input bit wval, input string req);
        step(0, 8'h0, 16'h0, 1, wa, wv, wp, wval, 0, req);
    endtask

    task automatic sweep(input logic [7:0] la, input string req);
        for (int v = 0; v < 256; v++)
            lookup(la, {8'(v), 8'(v) ^ 8'h5A}, req);
    endtask

    task automatic slots(input string req);
        for (int i = 0; i < N; i++)
            lookup(8'd211, {8'(i * 29 + 5), 8'(i * 7)}, req);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_asid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0; m_v[i] = 0;
        end
        repeat (3) @(negedge clk);
        applied++;
        // R10: outputs quiet during reset
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0 || rsp_pa !== 16'h0) begin
            bad++;
            $display("FAIL R10: reset outputs v=%b h=%b m=%b pa=%h, expected 0 0 0 0000",
                     rsp_valid, rsp_hit, rsp_miss, rsp_pa);
        end
        rst_n = 1'b1;
        lookup(8'h00, 16'h0000, "R10");
        lookup(8'd211, 16'h0540, "R5");
        step(0, 8'h0, 16'h0, 0, 8'h0, 8'h0, 8'h0, 0, 0, "R4");

        for (int i = 0; i < N; i++)
            fill(8'd211, 8'(i * 29 + 5), 8'(8'h80 + i), 1, "R7");
        lookup(8'd211, 16'h0540, "R5");
        sweep(8'd211, "R1");
        sweep(8'd122, "R2");

        // R6: in-place update of slot holding page 0x22
        fill(8'd211, 8'h22, 8'h55, 1, "R6");
        slots("R6");
        // R3: invalidate the same tag
        fill(8'd211, 8'h22, 8'h55, 0, "R3");
        lookup(8'd211, 16'h2210, "R3");
        slots("R3");
        // R7: pointer wrapped to slot 0, page 0x05 evicted
        fill(8'd211, 8'hF0, 8'h33, 1, "R7");
        lookup(8'd211, 16'h0501, "R7");
        lookup(8'd211, 16'hF0AB, "R7");
        // R9: dropped invalid fill does not move the pointer
        fill(8'd7, 8'h09, 8'h44, 0, "R9");
        lookup(8'd7, 16'h0900, "R9");
        fill(8'd7, 8'h09, 8'h44, 1, "R9");
        slots("R9");
        lookup(8'd7, 16'h09FF, "R9");

        // R2: same page, two tags
        fill(8'd122, 8'h05, 8'h91, 1, "R2");
        fill(8'd211, 8'h05, 8'h12, 1, "R2");
        lookup(8'd122, 16'h0519, "R2");
        lookup(8'd211, 16'h0519, "R2");
        fill(8'd211, 8'hBB, 8'h91, 1, "R1");
        lookup(8'd211, 16'hBB13, "R1");

        // R4: lookup with same-edge fill sees old contents
        step(1, 8'd211, 16'h7700, 1, 8'd211, 8'h77, 8'h66, 1, 0, "R4");
        lookup(8'd211, 16'h7701, "R4");
        step(0, 8'h0, 16'h0, 0, 8'h0, 8'h0, 8'h0, 0, 0, "R4");

        // R8: flush with same-edge lookup, then everything misses
        step(1, 8'd211, 16'hBB00, 0, 8'h0, 8'h0, 8'h0, 0, 1, "R8");
        sweep(8'd211, "R8");
        step(0, 8'h0, 16'h0, 1, 8'd9, 8'h12, 8'h34, 1, 1, "R8");
        lookup(8'd9, 16'h1200, "R8");
        fill(8'd9, 8'h13, 8'h21, 1, "R8");
        lookup(8'd9, 16'h1377, "R8");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, got no completion, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule